// File: doc/BRIEF.md
# Stage-2 Translation Cache with Address-Targeted Invalidation

This block is a small, fully associative cache of stage-2 translation entries. Each slot holds an intermediate physical page number, the virtual machine identifier that owns it, a physical page number and four attribute fields: a non-secure bit, a guest-regime bit, a final-level flag and a two-bit stage kind. A lookup compares the requested page and the current machine identifier against every slot and returns the stored physical page in the same cycle. A fill writes one slot chosen by a round-robin pointer.

The invalidate command takes a 32-bit operand whose low 28 bits name the page to drop. It removes only slots that are valid, non-secure, guest-regime, final-level and stage-2-only, and whose page and machine identifier match the operand and the current identifier. Walk-cache (non-final) entries and entries of any other stage kind stay. The command takes one cycle, and a completion pulse follows one cycle later.

A two-state controller tracks the command: `CT_IDLE` (no command in the last cycle) and `CT_ACK` (a command was accepted in the last cycle; `inv_done` is high). The transition `ACCEPT` moves to `CT_ACK` whenever `inv_valid` is high. The transition `RETIRE` returns to `CT_IDLE` when `inv_valid` is low. A command arriving while in `CT_ACK` keeps the controller in `CT_ACK` (the `REPEAT` transition).

Top module: `s2_tlb`

## Requirements
- R1: When `lk_valid` is high and a valid slot matches both `lk_ipa` and `cur_vmid`, `lk_hit` is 1 in the same cycle and `lk_ppn` holds that slot's physical page. If several slots match, the lowest-numbered slot wins. Otherwise `lk_hit` is 0 and `lk_ppn` is 0.
- R2: A fill writes the slot named by a round-robin pointer. The pointer starts at slot 0 after reset, advances by one on every fill and wraps after the last slot. An overwritten entry no longer hits.
- R3: An invalidate clears every slot that meets all of these conditions: it is valid, its page equals operand bits [27:0], its machine identifier equals `cur_vmid`, its stage kind is 2'b10, its final-level flag is 1, its non-secure bit is 1 and its guest-regime bit is 1.
- R4: Operand bits [31:28] have no effect on which slots are cleared.
- R5: Slots whose stage kind is not 2'b10 survive an invalidate. The stage-kind encodings are 2'b01 for stage-1 only, 2'b10 for stage-2 only and 2'b11 for merged stage-1/stage-2.
- R6: Slots whose final-level flag is 0 survive an invalidate.
- R7: Slots whose machine identifier differs from `cur_vmid` survive an invalidate.
- R8: Slots whose non-secure bit is 0, or whose guest-regime bit is 0, survive an invalidate.
- R9: When an invalidate and a fill arrive in the same cycle, the invalidate is applied first and the fill then writes its slot. A filled entry that matches the same command is therefore present afterwards.
- R10: `inv_done` is 1 in the cycle after each cycle with `inv_valid` high, and 0 after every cycle without one.
- R11: After reset no slot is valid, lookups miss and `inv_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ipa | input | 28 | Page number to look up |
| cur_vmid | input | 8 | Current virtual machine identifier, used by lookup and invalidate |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_ppn | output | 28 | Physical page of the hitting slot, 0 on miss |
| fill_valid | input | 1 | Write a new entry |
| fill_ipa | input | 28 | Page number of the new entry |
| fill_vmid | input | 8 | Machine identifier of the new entry |
| fill_ns | input | 1 | Non-secure bit of the new entry |
| fill_guest | input | 1 | 1 when the entry belongs to the guest kernel/user regime |
| fill_last | input | 1 | 1 when the entry comes from the final walk level |
| fill_stage | input | 2 | Stage kind: 01 stage-1, 10 stage-2 only, 11 merged |
| fill_ppn | input | 28 | Physical page of the new entry |
| inv_valid | input | 1 | Invalidate command |
| inv_operand | input | 32 | Invalidate operand; bits [27:0] hold the page, bits [31:28] are ignored |
| inv_done | output | 1 | Completion pulse, one cycle after the command |

## Verification
The assertions assume that the slot count is a power of two, so the fill pointer wraps by plain overflow, and that `inv_valid` and `fill_valid` are never unknown after reset. The slot-survival properties assume that only a same-cycle fill can revalidate a slot, so they are armed only in cycles without a fill. The bench drives every input on the falling edge and holds it for one full cycle. It reaches the same-cycle command-plus-fill case only through a dedicated step. Duplicate page/identifier pairs are created on purpose, so that the survivor of an invalidate shows up on the lookup port.

// File: rtl/s2tlb_pkg.sv
package s2tlb_pkg;

    typedef enum logic [1:0] {
        STG_NONE = 2'b00,
        STG_S1   = 2'b01,
        STG_S2   = 2'b10,
        STG_S12  = 2'b11
    } stage_e;

    typedef struct packed {
        logic   ns;
        logic   guest;
        logic   last;
        stage_e stage;
    } ent_attr_t;

    typedef enum logic {
        CT_IDLE = 1'b0,
        CT_ACK  = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/s2tlb_rr_ptr.sv
module s2tlb_rr_ptr #(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [PTR_W-1:0] slot
);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (advance) begin
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        end
    end

    assign slot = slot_q;

endmodule

// File: rtl/s2tlb_ctrl.sv
module s2tlb_ctrl
    import s2tlb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inv_valid,
    output logic inv_go,
    output logic inv_done
);
    ctrl_state_e state_q, state_d;

    // next-state: ACCEPT / REPEAT go to CT_ACK, RETIRE returns to CT_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_IDLE: state_d = inv_valid ? CT_ACK : CT_IDLE;
            CT_ACK:  state_d = inv_valid ? CT_ACK : CT_IDLE;
            default: state_d = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        inv_go   = inv_valid;
        inv_done = 1'b0;
        unique case (state_q)
            CT_IDLE: inv_done = 1'b0;
            CT_ACK:  inv_done = 1'b1;
            default: inv_done = 1'b0;
        endcase
    end

endmodule

// File: rtl/s2tlb_store.sv
module s2tlb_store
    import s2tlb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int IPA_W  = 28,
    parameter int VMID_W = 8,
    parameter int PPN_W  = 28,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [IPA_W-1:0]  lk_ipa,
    input  logic [VMID_W-1:0] cur_vmid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    input  logic              fill_we,
    input  logic [PTR_W-1:0]  fill_slot,
    input  logic [IPA_W-1:0]  fill_ipa,
    input  logic [VMID_W-1:0] fill_vmid,
    input  ent_attr_t         fill_attr,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              inv_go,
    input  logic [IPA_W-1:0]  inv_ipa,
    output logic [DEPTH-1:0]  ent_valid,
    output logic [DEPTH-1:0]  ent_last,
    output logic [DEPTH-1:0]  ent_s2
);
    logic [DEPTH-1:0]  valid_q;
    logic [IPA_W-1:0]  ipa_q  [DEPTH];
    logic [VMID_W-1:0] vmid_q [DEPTH];
    logic [PPN_W-1:0]  ppn_q  [DEPTH];
    ent_attr_t         attr_q [DEPTH];
    logic [DEPTH-1:0]  lk_match;
    logic [DEPTH-1:0]  inv_match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic write_here;
        logic owner_ok;
        logic kind_ok;

        assign write_here = fill_we && (fill_slot == PTR_W'(i));
        assign owner_ok   = attr_q[i].ns && attr_q[i].guest;
        assign kind_ok    = attr_q[i].last && (attr_q[i].stage == STG_S2);

        assign lk_match[i]  = valid_q[i] && (ipa_q[i] == lk_ipa) && (vmid_q[i] == cur_vmid);
        assign inv_match[i] = valid_q[i] && owner_ok && kind_ok &&
                              (ipa_q[i] == inv_ipa) && (vmid_q[i] == cur_vmid);

        // invalidate first, then the fill overwrites its slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
            end else if (write_here) begin
                valid_q[i] <= 1'b1;
            end else if (inv_go && inv_match[i]) begin
                valid_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (write_here) begin
                ipa_q[i]  <= fill_ipa;
                vmid_q[i] <= fill_vmid;
                ppn_q[i]  <= fill_ppn;
                attr_q[i] <= fill_attr;
            end
        end

        assign ent_last[i] = attr_q[i].last;
        assign ent_s2[i]   = (attr_q[i].stage == STG_S2);
    end

    assign ent_valid = valid_q;

    // lowest slot wins: scan from the top so lower indices overwrite
    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (lk_valid && lk_match[k]) begin
                lk_hit = 1'b1;
                lk_ppn = ppn_q[k];
            end
        end
    end

endmodule

// File: rtl/s2_tlb.sv
module s2_tlb
    import s2tlb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int IPA_W  = 28,
    parameter int VMID_W = 8,
    parameter int PPN_W  = 28,
    parameter int OP_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [IPA_W-1:0]  lk_ipa,
    input  logic [VMID_W-1:0] cur_vmid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    input  logic              fill_valid,
    input  logic [IPA_W-1:0]  fill_ipa,
    input  logic [VMID_W-1:0] fill_vmid,
    input  logic              fill_ns,
    input  logic              fill_guest,
    input  logic              fill_last,
    input  logic [1:0]        fill_stage,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              inv_valid,
    input  logic [OP_W-1:0]   inv_operand,
    output logic              inv_done
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0] fill_slot;
    logic             inv_go;
    ent_attr_t        fill_attr;
    logic [IPA_W-1:0] inv_ipa;
    logic [DEPTH-1:0] ent_valid;
    logic [DEPTH-1:0] ent_last;
    logic [DEPTH-1:0] ent_s2;
    logic             unused_rsvd;

    assign inv_ipa     = inv_operand[IPA_W-1:0];
    assign unused_rsvd = ^inv_operand[OP_W-1:IPA_W];

    assign fill_attr.ns    = fill_ns;
    assign fill_attr.guest = fill_guest;
    assign fill_attr.last  = fill_last;
    assign fill_attr.stage = stage_e'(fill_stage);

    s2tlb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv_valid(inv_valid),
        .inv_go   (inv_go),
        .inv_done (inv_done)
    );

    s2tlb_rr_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(fill_valid),
        .slot   (fill_slot)
    );

    s2tlb_store #(
        .DEPTH(DEPTH), .IPA_W(IPA_W), .VMID_W(VMID_W), .PPN_W(PPN_W), .PTR_W(PTR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_valid (lk_valid),
        .lk_ipa   (lk_ipa),
        .cur_vmid (cur_vmid),
        .lk_hit   (lk_hit),
        .lk_ppn   (lk_ppn),
        .fill_we  (fill_valid),
        .fill_slot(fill_slot),
        .fill_ipa (fill_ipa),
        .fill_vmid(fill_vmid),
        .fill_attr(fill_attr),
        .fill_ppn (fill_ppn),
        .inv_go   (inv_go),
        .inv_ipa  (inv_ipa),
        .ent_valid(ent_valid),
        .ent_last (ent_last),
        .ent_s2   (ent_s2)
    );

endmodule

// File: rtl/s2tlb_chk.sv
module s2tlb_chk #(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int PPN_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_hit,
    input logic [PPN_W-1:0] lk_ppn,
    input logic             fill_valid,
    input logic             inv_valid,
    input logic             inv_done,
    input logic [PTR_W-1:0] fill_slot,
    input logic [DEPTH-1:0] ent_valid,
    input logic [DEPTH-1:0] ent_last,
    input logic [DEPTH-1:0] ent_s2
);
    p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> inv_done);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_valid |=> !inv_done);

    p_no_hit_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

    p_miss_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0));

    p_fill_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> ent_valid[$past(fill_slot)]);

    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (fill_slot == $past(fill_slot) + 1'b1));

    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> $stable(fill_slot));

    for (genvar i = 0; i < DEPTH; i++) begin : g_keep
        p_keep_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (inv_valid && !fill_valid && ent_valid[i] && !ent_last[i]) |=> ent_valid[i]);

        p_keep_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (inv_valid && !fill_valid && ent_valid[i] && !ent_s2[i]) |=> ent_valid[i]);

        p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!fill_valid && !ent_valid[i]) |=> !ent_valid[i]);
    end

endmodule

bind s2_tlb s2tlb_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W), .PPN_W(PPN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_hit    (lk_hit),
    .lk_ppn    (lk_ppn),
    .fill_valid(fill_valid),
    .inv_valid (inv_valid),
    .inv_done  (inv_done),
    .fill_slot (fill_slot),
    .ent_valid (ent_valid),
    .ent_last  (ent_last),
    .ent_s2    (ent_s2)
);

// File: tb/sim_s2_tlb.sv
module sim_s2_tlb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [27:0] lk_ipa = '0;
    logic [7:0]  cur_vmid = '0;
    logic        lk_hit;
    logic [27:0] lk_ppn;
    logic        fill_valid = 1'b0;
    logic [27:0] fill_ipa = '0;
    logic [7:0]  fill_vmid = '0;
    logic        fill_ns = 1'b0;
    logic        fill_guest = 1'b0;
    logic        fill_last = 1'b0;
    logic [1:0]  fill_stage = 2'b00;
    logic [27:0] fill_ppn = '0;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_operand = '0;
    logic        inv_done;

    always #5 clk = ~clk;

    s2_tlb u0 (.*);

    typedef struct {
        logic [27:0] ipa; logic [7:0] vmid;
        logic ns; logic g; logic last; logic [1:0] stg; logic [27:0] ppn;
    } fent_t;

    typedef struct { string req; logic hit; logic [27:0] ppn; } exp_t;

    int    n_chk = 0;
    int    n_fail = 0;
    exp_t  sb[$];
    fent_t m_e[N];
    logic  m_v[N];
    int    m_ptr = 0;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic fent_t mk(logic [27:0] ipa, logic [7:0] vm, logic ns, logic g,
                                 logic last, logic [1:0] stg, logic [27:0] ppn);
        fent_t f;
        f.ipa = ipa; f.vmid = vm; f.ns = ns; f.g = g; f.last = last; f.stg = stg; f.ppn = ppn;
        return f;
    endfunction

    task automatic clear_pins();
        lk_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0;
    endtask

    task automatic put_fill(fent_t f);
        fill_valid = 1'b1; fill_ipa = f.ipa; fill_vmid = f.vmid; fill_ns = f.ns;
        fill_guest = f.g; fill_last = f.last; fill_stage = f.stg; fill_ppn = f.ppn;
        m_e[m_ptr] = f; m_v[m_ptr] = 1'b1;
        m_ptr = (m_ptr + 1) % N;
    endtask

    task automatic model_inv(logic [31:0] op, logic [7:0] vm);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_e[i].ipa == op[27:0] && m_e[i].vmid == vm && m_e[i].stg == 2'b10
                && m_e[i].last && m_e[i].ns && m_e[i].g)
                m_v[i] = 1'b0;
    endtask

    task automatic do_fill(fent_t f);
        @(negedge clk); clear_pins(); put_fill(f);
    endtask

    // driver: drive a lookup and push the model's expectation
    task automatic look(logic [27:0] ipa, logic [7:0] vm, string req);
        exp_t e;
        @(negedge clk); clear_pins();
        lk_valid = 1'b1; lk_ipa = ipa; cur_vmid = vm;
        e.req = req; e.hit = 1'b0; e.ppn = '0;
        for (int i = N - 1; i >= 0; i--)
            if (m_v[i] && m_e[i].ipa == ipa && m_e[i].vmid == vm) begin
                e.hit = 1'b1; e.ppn = m_e[i].ppn;
            end
        sb.push_back(e);
    endtask

    task automatic do_inv(logic [31:0] op, logic [7:0] vm, bit wf, fent_t f);
        @(negedge clk); clear_pins();
        inv_valid = 1'b1; inv_operand = op; cur_vmid = vm;
        model_inv(op, vm);
        if (wf) put_fill(f);
        @(negedge clk); clear_pins();
        check("R10 done pulse", 64'(inv_done), 64'd1);
    endtask

    // monitor: compare lookup results against the scoreboard
    always @(negedge clk) begin
        #2;
        if (lk_valid) begin
            if (sb.size() == 0) begin
                check("R1 scoreboard empty", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " hit"}, 64'(lk_hit), 64'(e.hit));
                check({e.req, " ppn"}, 64'(lk_ppn), 64'(e.ppn));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 64'd1, 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        fent_t nul;
        nul = mk(0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 done in reset", 64'(inv_done), 64'd0);
        rst_n = 1'b1;
        look(28'h100, 8'd5, "R11 empty after reset");

        // A: basic hit, wrong VMID miss, targeted removal
        do_fill(mk(28'h100, 5, 1, 1, 1, 2'b10, 28'hA0));
        look(28'h100, 8'd5, "R1 hit");
        look(28'h100, 8'd6, "R1 vmid mismatch");
        do_inv(32'h100, 8'd5, 0, nul);
        @(negedge clk);
        check("R10 done drops", 64'(inv_done), 64'd0);
        look(28'h100, 8'd5, "R3 target removed");

        // B: non-final entry survives (target in lower slot)
        do_fill(mk(28'h200, 5, 1, 1, 1, 2'b10, 28'hB2));
        do_fill(mk(28'h200, 5, 1, 1, 0, 2'b10, 28'hB1));
        look(28'h200, 8'd5, "R1 lowest slot wins");
        do_inv(32'h200, 8'd5, 0, nul);
        look(28'h200, 8'd5, "R6 upper-level kept");

        // C: merged-stage entry survives
        do_fill(mk(28'h300, 5, 1, 1, 1, 2'b10, 28'hC2));
        do_fill(mk(28'h300, 5, 1, 1, 1, 2'b11, 28'hC1));
        do_inv(32'h300, 8'd5, 0, nul);
        look(28'h300, 8'd5, "R5 merged kept");

        // D: other VMID survives
        do_fill(mk(28'h400, 5, 1, 1, 1, 2'b10, 28'hD2));
        do_fill(mk(28'h400, 6, 1, 1, 1, 2'b10, 28'hD1));
        do_inv(32'h400, 8'd5, 0, nul);
        look(28'h400, 8'd5, "R3 vmid5 removed");
        look(28'h400, 8'd6, "R7 vmid6 kept");

        // E: secure entry survives (decoy at slot 7, target wraps to slot 0)
        do_fill(mk(28'h500, 5, 0, 1, 1, 2'b10, 28'hE1));
        do_fill(mk(28'h500, 5, 1, 1, 1, 2'b10, 28'hE2));
        look(28'h500, 8'd5, "R2 wrap to slot 0");
        do_inv(32'h500, 8'd5, 0, nul);
        look(28'h500, 8'd5, "R8 secure kept");

        // F: host-regime entry survives; overwrites B's survivor
        do_fill(mk(28'h580, 5, 1, 1, 1, 2'b10, 28'hF2));
        do_fill(mk(28'h580, 5, 1, 0, 1, 2'b10, 28'hF1));
        look(28'h200, 8'd5, "R2 overwritten slot misses");
        do_inv(32'h580, 8'd5, 0, nul);
        look(28'h580, 8'd5, "R8 host regime kept");

        // G: reserved operand bits ignored
        do_fill(mk(28'h600, 5, 1, 1, 1, 2'b10, 28'h66));
        look(28'h600, 8'd5, "R4 before");
        do_inv(32'hA000_0600, 8'd5, 0, nul);
        look(28'h600, 8'd5, "R4 reserved bits ignored");

        // H: same-cycle invalidate and fill
        do_inv(32'h700, 8'd5, 1, mk(28'h700, 5, 1, 1, 1, 2'b10, 28'h77));
        look(28'h700, 8'd5, "R9 fill after invalidate");
        look(28'h300, 8'd5, "R2 slot 4 overwritten");

        // I: back-to-back commands
        @(negedge clk); clear_pins();
        inv_valid = 1'b1; inv_operand = 32'h900; cur_vmid = 8'd5;
        @(negedge clk);
        check("R10 first of pair", 64'(inv_done), 64'd1);
        inv_operand = 32'h901;
        @(negedge clk); clear_pins();
        check("R10 second of pair", 64'(inv_done), 64'd1);
        @(negedge clk);
        check("R10 after pair", 64'(inv_done), 64'd0);
        look(28'h700, 8'd5, "R9 entry untouched by others");

        @(negedge clk); clear_pins();
        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", 64'(sb.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule